// File: doc/BRIEF.md
# Directory Coherence Home Controller

This block is the home-node engine of a distributed shared-memory machine that has no broadcast medium. For every memory block it owns, it keeps a directory entry, one data word, and a presence vector with one bit per processor. A directory entry is in one of three states:

- **Uncached:** no processor holds the block.
- **Shared:** one or more processors hold clean copies, and memory is current.
- **Exclusive:** a single owner holds the block, and memory is stale.

Requesting nodes send three kinds of request: read misses, write misses and write-backs. A write to a block that the writer does not already own exclusively arrives as a write miss. The controller answers each request with an explicit reply. Before it can reply, it may first have to contact remote nodes, either to invalidate their copies or to fetch the owner's data.

Requests are served strictly one at a time, in the order they are accepted. While the controller is waiting for invalidation acknowledgements or for fetched data, it lowers its ready signal. All new requests, including those to the same block, wait until the current reply has been sent. The controller emits at most one outgoing message per cycle. Each outgoing message carries an opcode, a destination node, the block index and a data word.

Top module: `coh_home`

## Requirements
- R1: Reset leaves every block Uncached, with an empty presence vector and a zero data word. While reset is held, no message is sent and `req_ready` is low. Shortly after release, `req_ready` is high.
- R2: Request opcodes are 0 = read miss, 1 = write miss and 2 = write-back. A read miss to an Uncached or Shared block produces one data reply (message opcode 3) to the requester, carrying the stored word. The block becomes Shared and the requester is added to the presence vector.
- R3: A write miss to a block with no holder other than the requester produces an immediate data reply with the stored word. No invalidate or fetch is sent. The requester becomes the only Exclusive owner.
- R4: A write miss to a Shared block with other holders sends an invalidate (message opcode 0) to each other holder, one per cycle in ascending node order, and never to the requester. The data reply is sent only after as many acknowledgements (response kind 0) have arrived as invalidates were sent.
- R5: A read miss to a block owned Exclusive by another node sends a fetch (message opcode 1) to the owner. The word returned in a data response (response kind 1) is stored and forwarded in the data reply. The block becomes Shared, held by both the old owner and the requester.
- R6: A write miss to a block owned Exclusive by another node sends a fetch-invalidate (message opcode 2) to the owner. The returned word is stored and forwarded to the requester, which becomes the sole Exclusive owner.
- R7: A write-back from the Exclusive owner stores the written word, returns the block to Uncached with an empty presence vector, and is answered with an acknowledge (message opcode 4).
- R8: A write-back from a node that is not the Exclusive owner is acknowledged but changes neither the directory entry nor the stored word.
- R9: Only one request is in progress at a time. `req_ready` drops on the cycle after acceptance and returns only after the final reply cycle. The first message of a transaction appears in the cycle right after acceptance.
- R10: While waiting for fetched data, the controller ignores any response that does not come from the recorded owner or is not of the data kind. Such a response causes no message and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_op | input | 2 | Request opcode (0 read miss, 1 write miss, 2 write-back) |
| req_node | input | $clog2(NPROC) | Requesting node |
| req_blk | input | $clog2(NBLK) | Block index |
| req_wdata | input | WIDTH | Word carried by a write-back |
| rsp_valid | input | 1 | Remote response present |
| rsp_kind | input | 1 | 0 invalidate acknowledge, 1 fetched data |
| rsp_node | input | $clog2(NPROC) | Responding node |
| rsp_data | input | WIDTH | Fetched word |
| msg_valid | output | 1 | Outgoing message present this cycle |
| msg_op | output | 3 | 0 invalidate, 1 fetch, 2 fetch-invalidate, 3 data reply, 4 acknowledge |
| msg_node | output | $clog2(NPROC) | Destination node |
| msg_blk | output | $clog2(NBLK) | Block index of the message |
| msg_data | output | WIDTH | Data word (data replies only, otherwise zero) |

## Verification
The assertions assume that a request, once raised, is held until the controller accepts it. They also assume that remote responses arrive only as answers to messages the controller actually sent: one acknowledgement per invalidate, and fetched data only from the node that was fetched. The bench keeps to these assumptions. It raises each request from a task that holds it until `req_ready` is seen, and it produces acknowledgements and fetched words only after observing the matching outgoing message. The one deliberate exception is a stray response during a fetch wait, which tests that such a response is ignored.

// File: rtl/coh_home_pkg.sv
package coh_home_pkg;
  typedef enum logic [1:0] {DIR_UNC = 2'd0, DIR_SHR = 2'd1, DIR_EXC = 2'd2} dir_state_e;

  typedef enum logic [2:0] {
    H_IDLE  = 3'd0,
    H_INV   = 3'd1,
    H_WACK  = 3'd2,
    H_FETCH = 3'd3,
    H_WDATA = 3'd4,
    H_REPLY = 3'd5
  } home_state_e;

  localparam logic [1:0] OP_RD = 2'd0;
  localparam logic [1:0] OP_WR = 2'd1;
  localparam logic [1:0] OP_WB = 2'd2;

  localparam logic [2:0] MSG_INV       = 3'd0;
  localparam logic [2:0] MSG_FETCH     = 3'd1;
  localparam logic [2:0] MSG_FETCH_INV = 3'd2;
  localparam logic [2:0] MSG_DATA      = 3'd3;
  localparam logic [2:0] MSG_ACK       = 3'd4;

  localparam logic RSP_ACK  = 1'b0;
  localparam logic RSP_DATA = 1'b1;
endpackage

// File: rtl/coh_dir_array.sv
module coh_dir_array
  import coh_home_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int NBLK  = 8,
  parameter int WIDTH = 8,
  localparam int BW   = $clog2(NBLK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BW-1:0]    rd_addr,
  output dir_state_e       rd_state,
  output logic [NPROC-1:0] rd_vec,
  output logic [WIDTH-1:0] rd_data,
  input  logic             wr_en,
  input  logic [BW-1:0]    wr_addr,
  input  dir_state_e       wr_state,
  input  logic [NPROC-1:0] wr_vec,
  input  logic             dw_en,
  input  logic [BW-1:0]    dw_addr,
  input  logic [WIDTH-1:0] dw_data
);
  dir_state_e       st_a  [NBLK];
  logic [NPROC-1:0] vec_a [NBLK];
  logic [WIDTH-1:0] dat_a [NBLK];

  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    dir_state_e       st_r;
    logic [NPROC-1:0] vec_r;
    logic [WIDTH-1:0] dat_r;
    logic             ent_en, dat_en;

    assign ent_en = wr_en && (wr_addr == BW'(b));
    assign dat_en = dw_en && (dw_addr == BW'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_r  <= DIR_UNC;
        vec_r <= '0;
      end else if (ent_en) begin
        st_r  <= wr_state;
        vec_r <= wr_vec;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dat_r <= '0;
      else if (dat_en) dat_r <= dw_data;
    end

    assign st_a[b]  = st_r;
    assign vec_a[b] = vec_r;
    assign dat_a[b] = dat_r;
  end

  assign rd_state = st_a[rd_addr];
  assign rd_vec   = vec_a[rd_addr];
  assign rd_data  = dat_a[rd_addr];
endmodule

// File: rtl/coh_sharer_scan.sv
module coh_sharer_scan #(
  parameter int NPROC = 4,
  localparam int NW   = $clog2(NPROC),
  localparam int CW   = $clog2(NPROC + 1)
) (
  input  logic [NPROC-1:0] mask,
  output logic             any,
  output logic [NW-1:0]    first,
  output logic [CW-1:0]    cnt
);
  always_comb begin
    any   = |mask;
    first = '0;
    cnt   = '0;
    for (int i = NPROC - 1; i >= 0; i--) begin
      if (mask[i]) first = NW'(i);
    end
    for (int i = 0; i < NPROC; i++) begin
      cnt = cnt + CW'(mask[i]);
    end
  end
endmodule

// File: rtl/coh_home.sv
module coh_home
  import coh_home_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int NBLK  = 8,
  parameter int WIDTH = 8,
  localparam int NW   = $clog2(NPROC),
  localparam int BW   = $clog2(NBLK),
  localparam int CW   = $clog2(NPROC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [NW-1:0]    req_node,
  input  logic [BW-1:0]    req_blk,
  input  logic [WIDTH-1:0] req_wdata,
  input  logic             rsp_valid,
  input  logic             rsp_kind,
  input  logic [NW-1:0]    rsp_node,
  input  logic [WIDTH-1:0] rsp_data,
  output logic             msg_valid,
  output logic [2:0]       msg_op,
  output logic [NW-1:0]    msg_node,
  output logic [BW-1:0]    msg_blk,
  output logic [WIDTH-1:0] msg_data
);
  localparam logic [NPROC-1:0] ONE_HOT0 = NPROC'(1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  home_state_e      st_q, st_d;
  logic [1:0]       op_q;
  logic [NW-1:0]    src_q, own_q, own_d;
  logic [BW-1:0]    blk_q;
  logic [WIDTH-1:0] wd_q;
  logic [NPROC-1:0] pend_q, pend_d;
  logic [CW-1:0]    ackc_q, ackc_d;

  logic             accept, ack_hit, dat_hit;
  logic [BW-1:0]    lk_blk;
  logic [NW-1:0]    lk_src;
  logic [NPROC-1:0] src_oh, others;
  dir_state_e       rd_state, wr_state;
  logic [NPROC-1:0] rd_vec, wr_vec;
  logic [WIDTH-1:0] rd_data, dw_data;
  logic             wr_en, dw_en;
  logic             o_any, p_any;
  logic [NW-1:0]    o_first, p_first;
  logic [CW-1:0]    o_cnt, p_cnt;

  assign req_ready = (st_q == H_IDLE) && rst_core_n;
  assign accept    = req_valid && req_ready;
  assign lk_blk    = (st_q == H_IDLE) ? req_blk  : blk_q;
  assign lk_src    = (st_q == H_IDLE) ? req_node : src_q;
  assign src_oh    = ONE_HOT0 << lk_src;
  assign others    = rd_vec & ~src_oh;
  assign ack_hit   = rsp_valid && (rsp_kind == RSP_ACK) &&
                     ((st_q == H_INV) || (st_q == H_WACK)) && (ackc_q != '0);
  assign dat_hit   = rsp_valid && (rsp_kind == RSP_DATA) &&
                     (st_q == H_WDATA) && (rsp_node == own_q);

  coh_dir_array #(.NPROC(NPROC), .NBLK(NBLK), .WIDTH(WIDTH)) u_dir (
    .clk(clk), .rst_n(rst_core_n),
    .rd_addr(lk_blk), .rd_state(rd_state), .rd_vec(rd_vec), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(blk_q), .wr_state(wr_state), .wr_vec(wr_vec),
    .dw_en(dw_en), .dw_addr(blk_q), .dw_data(dw_data)
  );

  coh_sharer_scan #(.NPROC(NPROC)) u_scan_others (
    .mask(others), .any(o_any), .first(o_first), .cnt(o_cnt)
  );

  coh_sharer_scan #(.NPROC(NPROC)) u_scan_pend (
    .mask(pend_q), .any(p_any), .first(p_first), .cnt(p_cnt)
  );

  // next-state and message generation
  always_comb begin
    st_d      = st_q;
    pend_d    = pend_q;
    own_d     = own_q;
    ackc_d    = ackc_q - (ack_hit ? CW'(1) : CW'(0));
    msg_valid = 1'b0;
    msg_op    = MSG_ACK;
    msg_node  = src_q;
    msg_data  = '0;
    wr_en     = 1'b0;
    wr_state  = DIR_UNC;
    wr_vec    = '0;
    dw_en     = 1'b0;
    dw_data   = rsp_data;
    unique case (st_q)
      H_IDLE: begin
        if (accept) begin
          if (req_op == OP_RD) begin
            if (rd_state == DIR_EXC && o_any) begin
              st_d  = H_FETCH;
              own_d = o_first;
            end else begin
              st_d = H_REPLY;
            end
          end else if (req_op == OP_WR) begin
            if (rd_state == DIR_SHR && o_any) begin
              st_d   = H_INV;
              pend_d = others;
              ackc_d = o_cnt;
            end else if (rd_state == DIR_EXC && o_any) begin
              st_d  = H_FETCH;
              own_d = o_first;
            end else begin
              st_d = H_REPLY;
            end
          end else begin
            st_d = H_REPLY;
          end
        end
      end
      H_INV: begin
        msg_valid = p_any;
        msg_op    = MSG_INV;
        msg_node  = p_first;
        pend_d    = pend_q & ~(ONE_HOT0 << p_first);
        if (p_cnt <= CW'(1)) st_d = H_WACK;
      end
      H_WACK: begin
        if (ackc_q == '0) st_d = H_REPLY;
      end
      H_FETCH: begin
        msg_valid = 1'b1;
        msg_op    = (op_q == OP_WR) ? MSG_FETCH_INV : MSG_FETCH;
        msg_node  = own_q;
        st_d      = H_WDATA;
      end
      H_WDATA: begin
        if (dat_hit) begin
          dw_en = 1'b1;
          st_d  = H_REPLY;
        end
      end
      H_REPLY: begin
        msg_valid = 1'b1;
        st_d      = H_IDLE;
        if (op_q == OP_RD || op_q == OP_WR) begin
          msg_op   = MSG_DATA;
          msg_data = rd_data;
          wr_en    = 1'b1;
          wr_state = (op_q == OP_RD) ? DIR_SHR : DIR_EXC;
          wr_vec   = (op_q == OP_RD) ? (rd_vec | src_oh) : src_oh;
        end else if (op_q == OP_WB && rd_state == DIR_EXC && rd_vec == src_oh) begin
          wr_en    = 1'b1;
          wr_state = DIR_UNC;
          wr_vec   = '0;
          dw_en    = 1'b1;
          dw_data  = wd_q;
        end
      end
      default: st_d = H_IDLE;
    endcase
  end

  assign msg_blk = blk_q;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      st_q   <= H_IDLE;
      pend_q <= '0;
      ackc_q <= '0;
      own_q  <= '0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      ackc_q <= ackc_d;
      own_q  <= own_d;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      op_q  <= OP_RD;
      src_q <= '0;
      blk_q <= '0;
      wd_q  <= '0;
    end else if (accept) begin
      op_q  <= req_op;
      src_q <= req_node;
      blk_q <= req_blk;
      wd_q  <= req_wdata;
    end
  end
endmodule

// File: rtl/coh_home_chk.sv
module coh_home_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       msg_valid,
  input logic [2:0] msg_op
);
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!msg_valid && !req_ready);
    end
  end

  assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_msg_only_when_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> !req_ready);

  assert_inv_keeps_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_op == 3'd0) |=> !req_ready);

  assert_fetch_then_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && (msg_op == 3'd1 || msg_op == 3'd2)) |=> !msg_valid);

  assert_reply_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_op == 3'd3) |=> req_ready);

  assert_ack_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_op == 3'd4) |=> req_ready);
endmodule

bind coh_home coh_home_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .msg_valid(msg_valid), .msg_op(msg_op)
);

// File: tb/coh_home_test.sv
module coh_home_test;
  localparam int CLK_PERIOD = 10;
  localparam int NPROC = 4;
  localparam int NBLK  = 8;
  localparam int WIDTH = 8;

  localparam logic [1:0] Q_RD = 2'd0, Q_WR = 2'd1, Q_WB = 2'd2;
  localparam int M_INV = 0, M_FETCH = 1, M_FETCH_INV = 2, M_DATA = 3, M_ACK = 4;
  localparam logic K_ACK = 1'b0, K_DATA = 1'b1;

  logic clk, rst_n;
  logic req_valid, req_ready;
  logic [1:0] req_op;
  logic [1:0] req_node;
  logic [2:0] req_blk;
  logic [WIDTH-1:0] req_wdata;
  logic rsp_valid, rsp_kind;
  logic [1:0] rsp_node;
  logic [WIDTH-1:0] rsp_data;
  logic msg_valid;
  logic [2:0] msg_op;
  logic [1:0] msg_node;
  logic [2:0] msg_blk;
  logic [WIDTH-1:0] msg_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  coh_home #(.NPROC(NPROC), .NBLK(NBLK), .WIDTH(WIDTH)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_node(req_node), .req_blk(req_blk), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_node(rsp_node), .rsp_data(rsp_data),
    .msg_valid(msg_valid), .msg_op(msg_op), .msg_node(msg_node),
    .msg_blk(msg_blk), .msg_data(msg_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check_eq(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic send_req(logic [1:0] op, int node, int blk, int data);
    @(negedge clk);
    req_valid = 1'b1;
    req_op    = op;
    req_node  = 2'(node);
    req_blk   = 3'(blk);
    req_wdata = WIDTH'(data);
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    req_valid <= 1'b0;
  endtask

  task automatic send_rsp(logic kind, int node, int data);
    @(negedge clk);
    rsp_valid = 1'b1;
    rsp_kind  = kind;
    rsp_node  = 2'(node);
    rsp_data  = WIDTH'(data);
    @(posedge clk);
    rsp_valid <= 1'b0;
  endtask

  task automatic expect_msg(string tag, int op, int node, int blk, int data);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (msg_valid) break;
    end
    check_eq(tag, "msg_valid", int'(msg_valid), 1);
    check_eq(tag, "msg_op", int'(msg_op), op);
    check_eq(tag, "msg_node", int'(msg_node), node);
    check_eq(tag, "msg_blk", int'(msg_blk), blk);
    check_eq(tag, "msg_data", int'(msg_data), data);
    check_eq("R9", "req_ready during message", int'(req_ready), 0);
  endtask

  task automatic expect_quiet(string tag);
    @(negedge clk);
    check_eq(tag, "msg_valid while waiting", int'(msg_valid), 0);
    check_eq("R9", "req_ready while waiting", int'(req_ready), 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    req_valid = 1'b0; req_op = '0; req_node = '0; req_blk = '0; req_wdata = '0;
    rsp_valid = 1'b0; rsp_kind = 1'b0; rsp_node = '0; rsp_data = '0;
    repeat (3) @(negedge clk);
    check_eq("R1", "msg_valid in reset", int'(msg_valid), 0);
    check_eq("R1", "req_ready in reset", int'(req_ready), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_eq("R1", "req_ready after reset", int'(req_ready), 1);
    check_eq("R1", "msg_valid after reset", int'(msg_valid), 0);
  endtask

  task automatic t_read_uncached_and_shared;
    send_req(Q_RD, 0, 2, 0);
    expect_msg("R2", M_DATA, 0, 2, 0);
    send_req(Q_RD, 2, 2, 0);
    expect_msg("R2", M_DATA, 2, 2, 0);
  endtask

  task automatic t_write_shared_inv;
    send_req(Q_WR, 1, 2, 0);
    expect_msg("R4", M_INV, 0, 2, 0);
    expect_msg("R4", M_INV, 2, 2, 0);
    expect_quiet("R4");
    send_rsp(K_ACK, 0, 0);
    expect_quiet("R4");
    send_rsp(K_ACK, 2, 0);
    expect_msg("R4", M_DATA, 1, 2, 0);
  endtask

  task automatic t_writeback_owner;
    send_req(Q_WB, 1, 2, 'h5A);
    expect_msg("R7", M_ACK, 1, 2, 0);
    send_req(Q_RD, 3, 2, 0);
    expect_msg("R7", M_DATA, 3, 2, 'h5A);
  endtask

  task automatic t_write_sole_sharer;
    send_req(Q_WR, 3, 2, 0);
    expect_msg("R3", M_DATA, 3, 2, 'h5A);
    send_req(Q_RD, 0, 2, 0);
    expect_msg("R3", M_FETCH, 3, 2, 0);
    send_rsp(K_DATA, 3, 'h66);
    expect_msg("R5", M_DATA, 0, 2, 'h66);
  endtask

  task automatic t_write_uncached;
    send_req(Q_WR, 2, 5, 0);
    expect_msg("R3", M_DATA, 2, 5, 0);
  endtask

  task automatic t_read_exclusive;
    send_req(Q_RD, 0, 5, 0);
    expect_msg("R5", M_FETCH, 2, 5, 0);
    send_rsp(K_DATA, 1, 'hEE);
    expect_quiet("R10");
    send_rsp(K_ACK, 2, 'hEE);
    expect_quiet("R10");
    send_rsp(K_DATA, 2, 'hC3);
    expect_msg("R5", M_DATA, 0, 5, 'hC3);
    send_req(Q_WR, 0, 5, 0);
    expect_msg("R5", M_INV, 2, 5, 0);
    send_rsp(K_ACK, 2, 0);
    expect_msg("R4", M_DATA, 0, 5, 'hC3);
  endtask

  task automatic t_writeback_nonowner;
    send_req(Q_WB, 3, 5, 'h11);
    expect_msg("R8", M_ACK, 3, 5, 0);
    send_req(Q_WR, 1, 5, 0);
    expect_msg("R8", M_FETCH_INV, 0, 5, 0);
    send_rsp(K_DATA, 0, 'h77);
    expect_msg("R6", M_DATA, 1, 5, 'h77);
    send_req(Q_RD, 2, 5, 0);
    expect_msg("R6", M_FETCH, 1, 5, 0);
    send_rsp(K_DATA, 1, 'h78);
    expect_msg("R6", M_DATA, 2, 5, 'h78);
  endtask

  task automatic report;
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_read_uncached_and_shared();
    t_write_shared_inv();
    t_writeback_owner();
    t_write_sole_sharer();
    t_write_uncached();
    t_read_exclusive();
    t_writeback_nonowner();
    repeat (3) @(negedge clk);
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R9 watchdog: actual hung expected finished");
    report();
  end
endmodule